// File: doc/BRIEF.md
# Stop-Mode Entry and Wakeup Controller

This block sequences a small processor core into and out of its deepest power-saving state. Software writes the stop-request bit (bit 7 of the system control word, brought to this block as `ctl_stop` qualified by `ctl_wr`). While running, that write turns off the oscillator enable, holds the prescaler and timing divider in clear, and removes the core clock enable. The core sits there until a release condition is seen. Release is followed by a counted warm-up and then a return to normal running.

Two release behaviours exist, chosen by `lvl_mode`. In level mode, the release pin being high releases the stop. So does any enabled key-wakeup input that is low. A stop request made while that condition already holds never stops the oscillator: it goes straight into warm-up. In edge mode, only a rising edge on the release pin wakes the core, and the key inputs are not looked at. All pin inputs are asynchronous and pass through a synchronizer first.

The warm-up count advances on `ref_tick`, a pulse from a free-running slow reference. The stop request is dropped by itself when warm-up ends. All control and status pins are plain levels; no data stream passes through the block.

Top module: `stopctl_top`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) forces RUN: `state_o`=2'b00, `osc_en`=1, `core_clk_en`=1, `div_clr`=0. The state codes are RUN=2'b00, STOP=2'b01 and WARMUP=2'b10.
- R2: In RUN, a clock edge with `ctl_wr`=1 and `ctl_stop`=1 leaves RUN at that edge. A write with `ctl_stop`=0 has no effect.
- R3: In STOP, `osc_en`=0, `core_clk_en`=0 and `div_clr`=1.
- R4: In level mode (`lvl_mode`=1), the release pin high releases STOP. Each pin passes through a two-flop synchronizer, so WARMUP shows on the third rising edge after the pin change and not on the second.
- R5: In level mode, key input `key_n[i]` low releases STOP only when `key_en[i]`=1. A low key whose enable bit is 0 leaves the block in STOP.
- R6: In level mode, a stop request made while the release condition (pin high or an enabled key low) already holds goes from RUN to WARMUP directly, and `osc_en` stays 1.
- R7: In edge mode (`lvl_mode`=0), a stop request always enters STOP. Only a rising edge of the release pin seen while in STOP releases it. A pin held high, and key inputs at any level, leave it in STOP.
- R8: In WARMUP, `osc_en`=1 and `core_clk_en`=0. The warm-up counter is loaded with `WARM_TICKS` on entry and counts down once per cycle with `ref_tick`=1. The block returns to RUN on the edge after the count reaches zero, which is `WARM_TICKS`+1 edges after entry when `ref_tick` is held high. With `ref_tick` low the block stays in WARMUP.
- R9: On return to RUN, `core_clk_en`=1 and the stop request is already cleared: with no new write, the block stays in RUN.
- R10: Writes made while the block is in STOP or WARMUP are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| ref_tick | input | 1 | One-cycle pulse from the slow reference; advances warm-up |
| ctl_wr | input | 1 | Control-word write strobe |
| ctl_stop | input | 1 | Stop-request bit of the written word (bit 7) |
| lvl_mode | input | 1 | 1 = level release, 0 = edge release |
| rel_pin | input | 1 | Asynchronous stop/release pin |
| key_n | input | N_KEY | Asynchronous key-wakeup inputs, active low |
| key_en | input | N_KEY | Per-key wakeup enable |
| osc_en | output | 1 | Oscillator enable |
| core_clk_en | output | 1 | Core clock enable |
| div_clr | output | 1 | Clear for prescaler and timing divider |
| state_o | output | 2 | Current state code |

## Verification
The stop-request write and a valid release condition can land in the same cycle. In level mode the bench sets the pin high, or pulls an enabled key low, and waits for the synchronizer to settle before it writes. It then expects WARMUP one edge after the write, with the oscillator never disabled. In edge mode the same overlap, with the pin already high at the write, must still produce STOP, and the held level must not count as an edge.

// File: rtl/stopctl_pkg.sv
`timescale 1ns/1ps
package stopctl_pkg;
  typedef enum logic [1:0] {
    ST_RUN  = 2'b00,
    ST_STOP = 2'b01,
    ST_WARM = 2'b10
  } stop_state_e;
endpackage

// File: rtl/stopctl_sync.sv
`timescale 1ns/1ps
// Multi-stage synchronizer, one independent chain per bit.
module stopctl_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_async,
  input  logic [W-1:0] rst_val,
  output logic [W-1:0] q_sync
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk) begin
      if (rst) chain_q <= {STAGES{rst_val[b]}};
      else     chain_q <= {chain_q[STAGES-2:0], d_async[b]};
    end
    assign q_sync[b] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/stopctl_wake.sv
`timescale 1ns/1ps
// Release-condition evaluation for both release behaviours.
module stopctl_wake #(
  parameter int N_KEY = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lvl_mode,
  input  logic             pin_s,
  input  logic [N_KEY-1:0] key_s,
  input  logic [N_KEY-1:0] key_en,
  output logic             lvl_hit,
  output logic             wake
);
  logic pin_prev_q;
  logic rise;

  always_ff @(posedge clk) begin
    if (rst) pin_prev_q <= 1'b0;
    else     pin_prev_q <= pin_s;
  end

  assign rise    = pin_s & ~pin_prev_q;
  assign lvl_hit = pin_s | (|(key_en & ~key_s));
  assign wake    = lvl_mode ? lvl_hit : rise;

  // R7: an edge-mode wake needs the pin to have been low the cycle before
  a_r7_edge_needs_low: assert property (@(posedge clk) disable iff (rst)
    (!lvl_mode && wake) |-> (pin_s && !pin_prev_q));
endmodule

// File: rtl/stopctl_warm.sv
`timescale 1ns/1ps
// Warm-up down-counter advanced by the slow reference tick.
module stopctl_warm #(
  parameter int WARM_TICKS = 16,
  localparam int CNT_W = (WARM_TICKS < 1) ? 1 : $clog2(WARM_TICKS + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic tick,
  output logic done
);
  localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(WARM_TICKS);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                       cnt_q <= '0;
    else if (load)                 cnt_q <= LOAD_VAL;
    else if (tick && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign done = (cnt_q == '0);

  // R8: count moves down by exactly one per tick
  a_r8_count_step: assert property (@(posedge clk) disable iff (rst)
    (!load && tick && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
  // R8: no tick, no movement
  a_r8_count_hold: assert property (@(posedge clk) disable iff (rst)
    (!load && !tick) |=> $stable(cnt_q));
endmodule

// File: rtl/stopctl_top.sv
`timescale 1ns/1ps
module stopctl_top
  import stopctl_pkg::*;
#(
  parameter int N_KEY       = 4,
  parameter int SYNC_STAGES = 2,
  parameter int WARM_TICKS  = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ref_tick,
  input  logic             ctl_wr,
  input  logic             ctl_stop,
  input  logic             lvl_mode,
  input  logic             rel_pin,
  input  logic [N_KEY-1:0] key_n,
  input  logic [N_KEY-1:0] key_en,
  output logic             osc_en,
  output logic             core_clk_en,
  output logic             div_clr,
  output logic [1:0]       state_o
);
  localparam int SW = N_KEY + 1;

  stop_state_e state_q, state_d;
  logic [SW-1:0] raw_in, sync_out, sync_rst;
  logic          pin_s;
  logic [N_KEY-1:0] key_s;
  logic          lvl_hit, wake, warm_done, warm_load, stop_req;

  assign raw_in   = {key_n, rel_pin};
  assign sync_rst = {{N_KEY{1'b1}}, 1'b0};

  stopctl_sync #(.W(SW), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d_async(raw_in), .rst_val(sync_rst), .q_sync(sync_out)
  );
  assign pin_s = sync_out[0];
  assign key_s = sync_out[SW-1:1];

  stopctl_wake #(.N_KEY(N_KEY)) u_wake (
    .clk(clk), .rst(rst), .lvl_mode(lvl_mode), .pin_s(pin_s),
    .key_s(key_s), .key_en(key_en), .lvl_hit(lvl_hit), .wake(wake)
  );

  assign stop_req = ctl_wr & ctl_stop;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN:  if (stop_req) state_d = (lvl_mode && lvl_hit) ? ST_WARM : ST_STOP;
      ST_STOP: if (wake)     state_d = ST_WARM;
      ST_WARM: if (warm_done) state_d = ST_RUN;
      default: state_d = ST_RUN;
    endcase
  end

  assign warm_load = (state_d == ST_WARM) && (state_q != ST_WARM);

  stopctl_warm #(.WARM_TICKS(WARM_TICKS)) u_warm (
    .clk(clk), .rst(rst), .load(warm_load), .tick(ref_tick), .done(warm_done)
  );

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_RUN;
    else     state_q <= state_d;
  end

  assign osc_en      = (state_q != ST_STOP);
  assign core_clk_en = (state_q == ST_RUN);
  assign div_clr     = (state_q == ST_STOP);
  assign state_o     = state_q;

  a_r1_reset_run: assert property (@(posedge clk)
    rst |=> (state_q == ST_RUN));
  a_r2_request_leaves: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_RUN && ctl_wr && ctl_stop) |=> (state_q != ST_RUN));
  a_r6_skip_to_warm: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_RUN && ctl_wr && ctl_stop && lvl_mode && lvl_hit) |=> (state_q == ST_WARM));
  a_r7_stop_holds: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_STOP && !wake) |=> (state_q == ST_STOP));
  a_r8_warm_holds: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_WARM && !warm_done) |=> (state_q == ST_WARM));
  a_r9_run_sticks: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_RUN && !(ctl_wr && ctl_stop)) |=> (state_q == ST_RUN));
  a_r3_no_warm_to_stop: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_WARM) |=> (state_q != ST_STOP));
endmodule

// File: tb/stopctl_top_tb_top.sv
`timescale 1ns/1ps
module stopctl_top_tb_top;
  localparam int NK = 4;
  localparam int WT = 5;

  logic clk = 1'b0;
  logic rst, ref_tick, ctl_wr, ctl_stop, lvl_mode, rel_pin;
  logic [NK-1:0] key_n, key_en;
  logic osc_en, core_clk_en, div_clr;
  logic [1:0] state_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done_flag = 1'b0;

  always #10 clk = ~clk;

  stopctl_top #(.N_KEY(NK), .SYNC_STAGES(2), .WARM_TICKS(WT)) dut_i (
    .clk(clk), .rst(rst), .ref_tick(ref_tick), .ctl_wr(ctl_wr), .ctl_stop(ctl_stop),
    .lvl_mode(lvl_mode), .rel_pin(rel_pin), .key_n(key_n), .key_en(key_en),
    .osc_en(osc_en), .core_clk_en(core_clk_en), .div_clr(div_clr), .state_o(state_o)
  );

  localparam logic [1:0] RUN = 2'b00, STP = 2'b01, WRM = 2'b10;

  // {lvl, pin0, keys0[4], en[4], skip, pin1, keys1[4], wake, pad[3]}
  localparam logic [19:0] VEC [0:7] = '{
    {1'b1, 1'b0, 4'hF, 4'hF, 1'b0, 1'b1, 4'hF, 1'b1, 3'b0}, // R4 pin release
    {1'b1, 1'b1, 4'hF, 4'hF, 1'b1, 1'b1, 4'hF, 1'b1, 3'b0}, // R6 pin already high
    {1'b1, 1'b0, 4'hF, 4'h4, 1'b0, 1'b0, 4'hB, 1'b1, 3'b0}, // R5 enabled key 2
    {1'b1, 1'b0, 4'hF, 4'h4, 1'b0, 1'b0, 4'hE, 1'b0, 3'b0}, // R5 disabled key 0
    {1'b1, 1'b0, 4'h7, 4'h8, 1'b1, 1'b0, 4'h7, 1'b1, 3'b0}, // R6 enabled key low
    {1'b0, 1'b0, 4'hF, 4'hF, 1'b0, 1'b1, 4'hF, 1'b1, 3'b0}, // R7 rising edge
    {1'b0, 1'b0, 4'hF, 4'hF, 1'b0, 1'b0, 4'h0, 1'b0, 3'b0}, // R7 keys ignored
    {1'b0, 1'b1, 4'hF, 4'hF, 1'b0, 1'b1, 4'hF, 1'b0, 3'b0}  // R7 held high, no edge
  };

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #5;
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic outs(input string req, input logic [1:0] st, input bit o, input bit c, input bit d);
    chk(req, "state", int'(state_o), int'(st));
    chk(req, "osc_en", int'(osc_en), int'(o));
    chk(req, "core_clk_en", int'(core_clk_en), int'(c));
    chk(req, "div_clr", int'(div_clr), int'(d));
  endtask

  task automatic do_reset();
    rst = 1'b1; ctl_wr = 1'b0; ctl_stop = 1'b0;
    step(2);
    rst = 1'b0;
  endtask

  task automatic write(input bit b);
    ctl_wr = 1'b1; ctl_stop = b;
    step(1);
    ctl_wr = 1'b0; ctl_stop = 1'b0;
  endtask

  initial begin
    #(20ns * 150000);
    if (!done_flag) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; ref_tick = 1'b1; ctl_wr = 1'b0; ctl_stop = 1'b0;
    lvl_mode = 1'b1; rel_pin = 1'b0; key_n = '1; key_en = '0;
    step(3);
    outs("R1", RUN, 1, 1, 0);
    rst = 1'b0;
    step(1);

    for (int v = 0; v < 8; v++) begin
      logic [19:0] e;
      e = VEC[v];
      do_reset();
      lvl_mode = e[19]; rel_pin = e[18]; key_n = e[17:14]; key_en = e[13:10];
      step(4);
      write(1'b1);
      if (e[9]) begin
        outs("R6", WRM, 1, 0, 0);
      end else begin
        outs("R3", STP, 0, 0, 1);
        rel_pin = e[8]; key_n = e[7:4];
        step(2);
        chk("R4", "still stopped at 2nd edge", int'(state_o), int'(STP));
        step(1);
        if (e[3]) chk(e[19] ? "R5" : "R7", "woke", int'(state_o), int'(WRM));
        else      chk(e[19] ? "R5" : "R7", "stayed", int'(state_o), int'(STP));
      end
      if (state_o == WRM) begin
        outs("R8", WRM, 1, 0, 0);
        step(WT);
        chk("R8", "warm at count end", int'(state_o), int'(WRM));
        step(1);
        outs("R9", RUN, 1, 1, 0);
        step(6);
        chk("R9", "no re-entry", int'(state_o), int'(RUN));
      end
    end

    // R2: write with stop bit clear
    do_reset();
    lvl_mode = 1'b1; rel_pin = 1'b0; key_n = '1; key_en = '1;
    step(4);
    write(1'b0);
    step(2);
    chk("R2", "bit clear ignored", int'(state_o), int'(RUN));

    // R10: write in STOP ignored; R4 release afterwards
    write(1'b1);
    chk("R2", "entered stop", int'(state_o), int'(STP));
    write(1'b1);
    step(3);
    chk("R10", "write in stop", int'(state_o), int'(STP));

    // R8: stalled warm-up with ref_tick low
    ref_tick = 1'b0;
    rel_pin = 1'b1;
    step(3);
    chk("R4", "level release", int'(state_o), int'(WRM));
    write(1'b1);
    step(WT + 4);
    chk("R8", "stall without tick", int'(state_o), int'(WRM));
    chk("R10", "write in warm-up", int'(state_o), int'(WRM));
    ref_tick = 1'b1;
    step(WT + 1);
    chk("R8", "resume after ticks", int'(state_o), int'(RUN));

    // R1: reset while stopped
    rel_pin = 1'b0;
    step(4);
    write(1'b1);
    chk("R3", "stopped", int'(state_o), int'(STP));
    rst = 1'b1;
    step(1);
    rst = 1'b0;
    outs("R1", RUN, 1, 1, 0);

    done_flag = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule